// File: doc/BRIEF.md
# Configurable Macrocell Register Cell

This block is one configurable logic cell of a programmable-logic fabric. Its data comes either from the OR of a small group of product terms or from a single product term taken directly. A configuration bit can invert that value. It then goes to a one-bit storage element that can act as an edge-triggered D register, a transparent latch or a toggle flip-flop. The clock is picked from several global clocks, a clock private to the cell, or a clock shared by the cell's group. A clock enable is picked from a global, a local or a product-term source. A global reset pin, a product-term reset and a product-term preset force the stored bit without waiting for a clock.

Every clock in the cell is modelled as a strobe level sampled on one system clock `clk`. A selected clock that is active in a `clk` cycle counts as a clock edge at the end of that cycle. Reset and preset work independently of the selected clock. They force the cell's registered value in the same `clk` cycle, and the stored bit keeps the forced value from the next `clk` edge on. The cell has two outputs: a feedback output toward the AND array and an interconnect output. Each one independently carries either the registered value or the combinational value, so that one registered function and one unrelated combinational function can leave the same cell.

The stored bit is a two-state machine with states ST_LOW and ST_HIGH. In each cycle exactly one transition is chosen:
- TR_HOLD keeps the state.
- TR_LOAD copies the data.
- TR_TOGGLE inverts the state.
- TR_FORCE_CLR goes to ST_LOW.
- TR_FORCE_SET goes to ST_HIGH.

The transitions are ranked in this order, highest first: TR_FORCE_CLR, TR_FORCE_SET, then TR_LOAD or TR_TOGGLE on an enabled clock, and TR_HOLD otherwise.

Top module: `mcell_top`

## Requirements
- R1: While `rst_n` is low the stored bit is 0, and any output that selects the registered value reads 0.
- R2: The combinational value is `pt_single` when `cfg_bypass`=1 and the OR of all bits of `pt_terms` when `cfg_bypass`=0. This value is XORed with `cfg_xor`.
- R3: With `cfg_mode`=0 (D register), the stored bit takes the combinational value at the end of a `clk` cycle in which the selected clock and the selected enable are both active. The new value is visible after that edge. In every other cycle the stored bit holds. `cfg_mode`=3 behaves as 0.
- R4: With `cfg_mode`=1 (latch), the registered value equals the combinational value in the same cycle while the selected clock and enable are both active. It holds the last such value while they are not.
- R5: With `cfg_mode`=2 (toggle), an enabled clock inverts the stored bit when the combinational value is 1 and leaves it unchanged when it is 0.
- R6: `cfg_clk_sel` picks `gclk[0]`, `gclk[1]` and `gclk[2]` for codes 0, 1 and 2, `pt_clk` for code 3, and `grp_clk` for code 4. Codes 5 to 7 select no clock. The unselected sources have no effect. When `cfg_clk_inv`=1 the selected clock is active when it is low.
- R7: `cfg_ce_sel` picks the enable: 0 is always enabled, 1 is `ce_glb`, 2 is `ce_loc` and 3 is `ce_pt`. When `cfg_ce_inv`=1 the selected enable source is active when it is low. Code 0 ignores `cfg_ce_inv`.
- R8: Reset is active when `grst_in` equals `grst_pol`, or when `pt_rst` differs from `cfg_rst_inv`. Preset is active when `pt_pre` differs from `cfg_pre_inv`. Either one forces the registered value (0 for reset, 1 for preset) in the same cycle without any clock, and the stored bit keeps that value after the edge.
- R9: When reset and preset are active together, reset wins and the value is 0.
- R10: `fb_out` carries the combinational value when `cfg_fb_comb`=1 and the registered value when it is 0. `ic_out` does the same, independently, under `cfg_ic_comb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all clock strobes are sampled |
| rst_n | input | 1 | Active-low system reset |
| cfg_mode | input | 2 | Storage mode: 0 D register, 1 latch, 2 toggle |
| cfg_bypass | input | 1 | 1 uses the single product term, 0 the OR of the terms |
| cfg_xor | input | 1 | Inverts the data value |
| cfg_clk_sel | input | 3 | Clock source code |
| cfg_clk_inv | input | 1 | Clock polarity, 1 = active low |
| cfg_ce_sel | input | 2 | Clock-enable source code |
| cfg_ce_inv | input | 1 | Enable polarity, 1 = active low |
| cfg_rst_inv | input | 1 | Product-term reset polarity, 1 = active low |
| cfg_pre_inv | input | 1 | Product-term preset polarity, 1 = active low |
| cfg_fb_comb | input | 1 | Feedback output takes the combinational value |
| cfg_ic_comb | input | 1 | Interconnect output takes the combinational value |
| grst_pol | input | 1 | Active level of the global reset pin |
| pt_terms | input | 4 | Product terms that are ORed together |
| pt_single | input | 1 | Single product term used when bypassing |
| gclk | input | 3 | Global clock strobes |
| pt_clk | input | 1 | Cell's own product-term clock strobe |
| grp_clk | input | 1 | Clock strobe shared by the cell group |
| ce_glb | input | 1 | Global clock enable |
| ce_loc | input | 1 | Local clock enable |
| ce_pt | input | 1 | Product-term clock enable |
| grst_in | input | 1 | Global reset pin |
| pt_rst | input | 1 | Product-term reset |
| pt_pre | input | 1 | Product-term preset |
| fb_out | output | 1 | Output toward the AND array |
| ic_out | output | 1 | Output toward the interconnect |

## Verification
The hardest situation to reach is the one where the force paths and the clock selection combine. An inverted clock polarity makes the idle level of a strobe an active clock. A reset arriving together with a preset must override both the preset and an enabled load in that same cycle. The stimulus first walks a vector table that moves through all three storage modes without clearing the stored bit in between. Each row therefore starts from the bit the previous row left behind. Directed tests then set an inverted clock or enable polarity and a low-active global reset pin. They also probe the combinational latch and preset paths in the middle of a cycle, before the next edge.

// File: rtl/mcell_pkg.sv
package mcell_pkg;

    // storage mode codes (cfg_mode); code 3 is treated as the D register
    localparam logic [1:0] MODE_DREG   = 2'd0;
    localparam logic [1:0] MODE_LATCH  = 2'd1;
    localparam logic [1:0] MODE_TOGGLE = 2'd2;

    // clock-enable source codes (cfg_ce_sel)
    localparam logic [1:0] CE_ALWAYS = 2'd0;
    localparam logic [1:0] CE_GLOBAL = 2'd1;
    localparam logic [1:0] CE_LOCAL  = 2'd2;
    localparam logic [1:0] CE_PTERM  = 2'd3;

    // the stored bit as a two-state machine
    typedef enum logic {
        ST_LOW,
        ST_HIGH
    } bit_state_e;

    // transition taken in a system-clock cycle
    typedef enum logic [2:0] {
        TR_HOLD,
        TR_LOAD,
        TR_TOGGLE,
        TR_FORCE_CLR,
        TR_FORCE_SET
    } step_e;

endpackage

// File: rtl/mcell_dsel.sv
module mcell_dsel #(
    parameter int N_PT = 4
) (
    input  logic [N_PT-1:0] pt_terms,
    input  logic            pt_single,
    input  logic            cfg_bypass,
    input  logic            cfg_xor,
    output logic            comb_d
);

    logic sum_of_terms;
    logic src_val;

    // wide OR of the product terms feeding this cell
    assign sum_of_terms = |pt_terms;

    always_comb begin
        src_val = cfg_bypass ? pt_single : sum_of_terms;
        comb_d  = src_val ^ cfg_xor;
    end

endmodule

// File: rtl/mcell_ctrl.sv
module mcell_ctrl #(
    parameter int N_GCLK = 3,
    localparam int N_CSRC = N_GCLK + 2,
    localparam int SEL_W  = $clog2(N_CSRC + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              grp_clk,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic              cfg_clk_inv,
    input  logic              ce_glb,
    input  logic              ce_loc,
    input  logic              ce_pt,
    input  logic [1:0]        cfg_ce_sel,
    input  logic              cfg_ce_inv,
    input  logic              grst_in,
    input  logic              grst_pol,
    input  logic              pt_rst,
    input  logic              cfg_rst_inv,
    input  logic              pt_pre,
    input  logic              cfg_pre_inv,
    output logic              fire,
    output logic              force_clr,
    output logic              force_set
);
    import mcell_pkg::*;

    logic [N_CSRC-1:0] clk_src;
    logic [N_CSRC-1:0] clk_hit;
    logic              clk_valid;
    logic              clk_level;
    logic              clk_act;
    logic              ce_act;

    // clock source vector: globals first, then own term clock, then group clock
    generate
        for (genvar g = 0; g < N_GCLK; g++) begin : g_gclk
            assign clk_src[g] = gclk[g];
        end
    endgenerate
    assign clk_src[N_GCLK]   = pt_clk;
    assign clk_src[N_GCLK+1] = grp_clk;

    // one decode line per source
    generate
        for (genvar s = 0; s < N_CSRC; s++) begin : g_dec
            assign clk_hit[s] = (cfg_clk_sel == SEL_W'(s));
        end
    endgenerate

    always_comb begin
        clk_valid = |clk_hit;
        clk_level = |(clk_src & clk_hit);
        clk_act   = clk_valid & (clk_level ^ cfg_clk_inv);
    end

    always_comb begin
        unique case (cfg_ce_sel)
            CE_ALWAYS: ce_act = 1'b1;
            CE_GLOBAL: ce_act = ce_glb ^ cfg_ce_inv;
            CE_LOCAL:  ce_act = ce_loc ^ cfg_ce_inv;
            CE_PTERM:  ce_act = ce_pt  ^ cfg_ce_inv;
            default:   ce_act = 1'b1;
        endcase
    end

    assign fire      = clk_act & ce_act;
    assign force_clr = (grst_in == grst_pol) | (pt_rst ^ cfg_rst_inv);
    assign force_set = pt_pre ^ cfg_pre_inv;

    AST_LOCAL_CE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ce_sel == CE_LOCAL && ce_loc == cfg_ce_inv) |-> !fire); // R7

    AST_GRST_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        (grst_in == grst_pol) |-> force_clr); // R8

    AST_BAD_SEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_clk_sel > SEL_W'(N_CSRC - 1)) |-> !fire); // R6

endmodule

// File: rtl/mcell_store.sv
module mcell_store (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode,
    input  logic       d,
    input  logic       fire,
    input  logic       force_clr,
    input  logic       force_set,
    output logic       q_reg,
    output logic       q_out
);
    import mcell_pkg::*;

    bit_state_e state_q;
    bit_state_e state_d;
    step_e      step;

    // transition choice, reset outranks preset, both outrank the clock
    always_comb begin
        step = TR_HOLD;
        if (force_clr) begin
            step = TR_FORCE_CLR;
        end else if (force_set) begin
            step = TR_FORCE_SET;
        end else if (fire) begin
            if (mode == MODE_TOGGLE) begin
                step = d ? TR_TOGGLE : TR_HOLD;
            end else begin
                step = TR_LOAD;
            end
        end
    end

    always_comb begin
        unique case (step)
            TR_HOLD:      state_d = state_q;
            TR_LOAD:      state_d = d ? ST_HIGH : ST_LOW;
            TR_TOGGLE:    state_d = (state_q == ST_HIGH) ? ST_LOW : ST_HIGH;
            TR_FORCE_CLR: state_d = ST_LOW;
            TR_FORCE_SET: state_d = ST_HIGH;
            default:      state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs: forces and an open latch act within the cycle
    always_comb begin
        q_reg = (state_q == ST_HIGH);
        unique case (step)
            TR_FORCE_CLR: q_out = 1'b0;
            TR_FORCE_SET: q_out = 1'b1;
            TR_LOAD:      q_out = (mode == MODE_LATCH) ? d : q_reg;
            default:      q_out = q_reg;
        endcase
    end

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_clr && force_set) |=> !q_reg); // R9

    AST_PRESET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (force_set && !force_clr) |=> q_reg); // R8

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && !force_clr && !force_set) |=> $stable(q_reg)); // R3

    AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_TOGGLE && fire && d && !force_clr && !force_set)
        |=> (q_reg != $past(q_reg))); // R5

    AST_LATCH_FLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_LATCH && fire && !force_clr && !force_set) |-> (q_out == d)); // R4

endmodule

// File: rtl/mcell_top.sv
module mcell_top #(
    parameter int N_PT   = 4,
    parameter int N_GCLK = 3,
    localparam int SEL_W = $clog2(N_GCLK + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_mode,
    input  logic              cfg_bypass,
    input  logic              cfg_xor,
    input  logic [SEL_W-1:0]  cfg_clk_sel,
    input  logic              cfg_clk_inv,
    input  logic [1:0]        cfg_ce_sel,
    input  logic              cfg_ce_inv,
    input  logic              cfg_rst_inv,
    input  logic              cfg_pre_inv,
    input  logic              cfg_fb_comb,
    input  logic              cfg_ic_comb,
    input  logic              grst_pol,
    input  logic [N_PT-1:0]   pt_terms,
    input  logic              pt_single,
    input  logic [N_GCLK-1:0] gclk,
    input  logic              pt_clk,
    input  logic              grp_clk,
    input  logic              ce_glb,
    input  logic              ce_loc,
    input  logic              ce_pt,
    input  logic              grst_in,
    input  logic              pt_rst,
    input  logic              pt_pre,
    output logic              fb_out,
    output logic              ic_out
);

    localparam int N_OUT = 2;

    logic comb_d;
    logic fire;
    logic force_clr;
    logic force_set;
    logic q_reg;
    logic q_out;
    logic [N_OUT-1:0] out_comb_sel;
    logic [N_OUT-1:0] out_val;

    mcell_dsel #(.N_PT(N_PT)) i_dsel (
        .pt_terms   (pt_terms),
        .pt_single  (pt_single),
        .cfg_bypass (cfg_bypass),
        .cfg_xor    (cfg_xor),
        .comb_d     (comb_d)
    );

    mcell_ctrl #(.N_GCLK(N_GCLK)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .gclk        (gclk),
        .pt_clk      (pt_clk),
        .grp_clk     (grp_clk),
        .cfg_clk_sel (cfg_clk_sel),
        .cfg_clk_inv (cfg_clk_inv),
        .ce_glb      (ce_glb),
        .ce_loc      (ce_loc),
        .ce_pt       (ce_pt),
        .cfg_ce_sel  (cfg_ce_sel),
        .cfg_ce_inv  (cfg_ce_inv),
        .grst_in     (grst_in),
        .grst_pol    (grst_pol),
        .pt_rst      (pt_rst),
        .cfg_rst_inv (cfg_rst_inv),
        .pt_pre      (pt_pre),
        .cfg_pre_inv (cfg_pre_inv),
        .fire        (fire),
        .force_clr   (force_clr),
        .force_set   (force_set)
    );

    mcell_store i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode      (cfg_mode),
        .d         (comb_d),
        .fire      (fire),
        .force_clr (force_clr),
        .force_set (force_set),
        .q_reg     (q_reg),
        .q_out     (q_out)
    );

    // index 0 feeds back to the AND array, index 1 drives the interconnect
    assign out_comb_sel = {cfg_ic_comb, cfg_fb_comb};

    generate
        for (genvar o = 0; o < N_OUT; o++) begin : g_out
            assign out_val[o] = out_comb_sel[o] ? comb_d : q_out;
        end
    endgenerate

    assign fb_out = out_val[0];
    assign ic_out = out_val[1];

endmodule

// File: tb/test_mcell_top.sv
module test_mcell_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] cfg_mode;
    logic       cfg_bypass, cfg_xor;
    logic [2:0] cfg_clk_sel;
    logic       cfg_clk_inv;
    logic [1:0] cfg_ce_sel;
    logic       cfg_ce_inv, cfg_rst_inv, cfg_pre_inv;
    logic       cfg_fb_comb, cfg_ic_comb, grst_pol;
    logic [3:0] pt_terms;
    logic       pt_single;
    logic [2:0] gclk;
    logic       pt_clk, grp_clk, ce_glb, ce_loc, ce_pt;
    logic       grst_in, pt_rst, pt_pre;
    logic       fb_out, ic_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    mcell_top i_mcell_top (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bypass(cfg_bypass),
        .cfg_xor(cfg_xor), .cfg_clk_sel(cfg_clk_sel), .cfg_clk_inv(cfg_clk_inv),
        .cfg_ce_sel(cfg_ce_sel), .cfg_ce_inv(cfg_ce_inv), .cfg_rst_inv(cfg_rst_inv),
        .cfg_pre_inv(cfg_pre_inv), .cfg_fb_comb(cfg_fb_comb), .cfg_ic_comb(cfg_ic_comb),
        .grst_pol(grst_pol), .pt_terms(pt_terms), .pt_single(pt_single), .gclk(gclk),
        .pt_clk(pt_clk), .grp_clk(grp_clk), .ce_glb(ce_glb), .ce_loc(ce_loc),
        .ce_pt(ce_pt), .grst_in(grst_in), .pt_rst(pt_rst), .pt_pre(pt_pre),
        .fb_out(fb_out), .ic_out(ic_out)
    );

    // row: mode[7:6] xor[5] single[4] gclk0[3] pt_rst[2] pt_pre[1] expected ic_out[0]
    localparam int NV = 15;
    localparam logic [7:0] VEC [NV] = '{
        8'b00_0_1_1_0_0_1,  // D load 1
        8'b00_0_0_0_0_0_1,  // D no clock holds
        8'b00_1_1_1_0_0_0,  // D with inversion
        8'b00_0_1_0_0_1_1,  // preset without clock
        8'b00_0_1_1_1_1_0,  // reset beats preset and load
        8'b10_0_1_1_0_0_1,  // T flip
        8'b10_0_1_1_0_0_0,  // T flip back
        8'b10_0_0_1_0_0_0,  // T data 0 holds
        8'b10_0_1_0_0_0_0,  // T no clock holds
        8'b10_0_1_1_0_0_1,  // T flip
        8'b01_0_0_1_0_0_0,  // latch open follows 0
        8'b01_0_1_0_0_0_0,  // latch closed holds
        8'b01_0_1_1_0_0_1,  // latch open follows 1
        8'b01_1_1_0_0_0_1,  // latch closed holds
        8'b01_1_1_1_0_0_0   // latch open follows inverted
    };

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic defaults();
        cfg_mode = 2'd0; cfg_bypass = 1'b1; cfg_xor = 1'b0;
        cfg_clk_sel = 3'd0; cfg_clk_inv = 1'b0; cfg_ce_sel = 2'd0; cfg_ce_inv = 1'b0;
        cfg_rst_inv = 1'b0; cfg_pre_inv = 1'b0; cfg_fb_comb = 1'b0; cfg_ic_comb = 1'b0;
        grst_pol = 1'b1; pt_terms = '0; pt_single = 1'b0; gclk = '0;
        pt_clk = 1'b0; grp_clk = 1'b0; ce_glb = 1'b0; ce_loc = 1'b0; ce_pt = 1'b0;
        grst_in = 1'b0; pt_rst = 1'b0; pt_pre = 1'b0;
    endtask

    // wait for the edge, then sample half way to the next falling edge
    task automatic edge_wait();
        @(posedge clk);
        #5;
    endtask

    // clear the stored bit through the product-term reset
    task automatic clear_bit();
        @(negedge clk);
        pt_rst = 1'b1;
        edge_wait();
        @(negedge clk);
        pt_rst = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        defaults();
        rst_n = 1'b0;
        pt_single = 1'b1;
        gclk[0] = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        chk(ic_out, 1'b0, "R1 reset ic_out");
        chk(fb_out, 1'b0, "R1 reset fb_out");
        @(negedge clk);
        defaults();
        rst_n = 1'b1;

        // table walk over the three storage modes
        for (int i = 0; i < NV; i++) begin
            string tag;
            @(negedge clk);
            cfg_mode  = VEC[i][7:6];
            cfg_xor   = VEC[i][5];
            pt_single = VEC[i][4];
            gclk[0]   = VEC[i][3];
            pt_rst    = VEC[i][2];
            pt_pre    = VEC[i][1];
            if (VEC[i][2] && VEC[i][1])      tag = "R9 table";
            else if (VEC[i][2] || VEC[i][1]) tag = "R8 table";
            else if (VEC[i][7:6] == 2'd0)    tag = "R3 table";
            else if (VEC[i][7:6] == 2'd1)    tag = "R4 table";
            else                             tag = "R5 table";
            edge_wait();
            chk(ic_out, VEC[i][0], $sformatf("%s row %0d", tag, i));
        end

        // R6: unselected global clock ignored, selected one loads
        @(negedge clk); defaults();
        clear_bit();
        cfg_clk_sel = 3'd1; pt_single = 1'b1; gclk[0] = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R6 gclk0 ignored when sel=1");
        @(negedge clk); gclk = 3'b010;
        edge_wait();
        chk(ic_out, 1'b1, "R6 gclk1 selected");

        // R6: group clock with inverted polarity
        @(negedge clk); defaults();
        clear_bit();
        cfg_clk_sel = 3'd4; cfg_clk_inv = 1'b1; pt_single = 1'b1; grp_clk = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R6 inverted group clock high is idle");
        @(negedge clk); grp_clk = 1'b0;
        edge_wait();
        chk(ic_out, 1'b1, "R6 inverted group clock low loads");

        // R6: own product-term clock, and an out-of-range code
        @(negedge clk); defaults();
        clear_bit();
        cfg_clk_sel = 3'd6; pt_single = 1'b1; gclk = 3'b111; pt_clk = 1'b1; grp_clk = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R6 code 6 selects no clock");
        @(negedge clk); cfg_clk_sel = 3'd3; gclk = '0; grp_clk = 1'b0;
        edge_wait();
        chk(ic_out, 1'b1, "R6 own term clock loads");

        // R7: enable sources and polarity
        @(negedge clk); defaults();
        clear_bit();
        gclk[0] = 1'b1; pt_single = 1'b1; cfg_ce_sel = 2'd2; cfg_ce_inv = 1'b1; ce_loc = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R7 inverted local enable high blocks");
        @(negedge clk); ce_loc = 1'b0;
        edge_wait();
        chk(ic_out, 1'b1, "R7 inverted local enable low loads");
        @(negedge clk); cfg_ce_sel = 2'd3; cfg_ce_inv = 1'b0; pt_single = 1'b0; ce_pt = 1'b0;
        edge_wait();
        chk(ic_out, 1'b1, "R7 term enable low blocks");
        @(negedge clk); ce_pt = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R7 term enable high loads");
        @(negedge clk); cfg_ce_sel = 2'd1; ce_glb = 1'b1; pt_single = 1'b1;
        edge_wait();
        chk(ic_out, 1'b1, "R7 global enable loads");

        // R8: low-active global reset pin, inverted term reset and preset
        @(negedge clk); defaults();
        grst_pol = 1'b0; grst_in = 1'b1;
        edge_wait();
        chk(ic_out, 1'b1, "R8 global reset inactive at its idle level");
        @(negedge clk); grst_in = 1'b0;
        edge_wait();
        chk(ic_out, 1'b0, "R8 low-active global reset clears");
        @(negedge clk); grst_in = 1'b1; cfg_pre_inv = 1'b1; pt_pre = 1'b0;
        #2;
        chk(ic_out, 1'b1, "R8 inverted preset acts within the cycle");
        @(negedge clk); pt_pre = 1'b1; cfg_rst_inv = 1'b1; pt_rst = 1'b0;
        #2;
        chk(ic_out, 1'b0, "R8 inverted term reset acts within the cycle");
        @(negedge clk); pt_rst = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R8 reset value kept after release");

        // R4: latch flow-through visible before the edge
        @(negedge clk); defaults();
        cfg_mode = 2'd1; gclk[0] = 1'b1; pt_single = 1'b1;
        #2;
        chk(ic_out, 1'b1, "R4 open latch passes data mid-cycle");

        // R10: independent outputs
        @(negedge clk); defaults();
        clear_bit();
        pt_single = 1'b1; cfg_fb_comb = 1'b1; cfg_ic_comb = 1'b0;
        edge_wait();
        chk(fb_out, 1'b1, "R10 fb_out combinational");
        chk(ic_out, 1'b0, "R10 ic_out registered");
        @(negedge clk); cfg_fb_comb = 1'b0; cfg_ic_comb = 1'b1; pt_single = 1'b0;
        edge_wait();
        chk(ic_out, 1'b0, "R10 ic_out combinational");
        @(negedge clk); pt_single = 1'b1;
        #2;
        chk(fb_out, 1'b0, "R10 fb_out registered unaffected");

        // R2: product-term OR path and inversion
        @(negedge clk); defaults();
        clear_bit();
        cfg_bypass = 1'b0; pt_terms = 4'b0100; gclk[0] = 1'b1;
        edge_wait();
        chk(ic_out, 1'b1, "R2 OR of terms loads 1");
        @(negedge clk); pt_terms = 4'b0000; pt_single = 1'b1;
        edge_wait();
        chk(ic_out, 1'b0, "R2 single term ignored without bypass");
        @(negedge clk); cfg_xor = 1'b1;
        edge_wait();
        chk(ic_out, 1'b1, "R2 inverted zero loads 1");

        // R3: code 3 acts as D register
        @(negedge clk); defaults();
        cfg_mode = 2'd3; gclk[0] = 1'b1; pt_single = 1'b0;
        edge_wait();
        chk(ic_out, 1'b0, "R3 mode 3 loads like D");

        done = 1'b1;
        finish_run();
    end

endmodule